// File: doc/BRIEF.md
# Clock Stop and Power-Up Sequencer

This block sits beside a clock generator and decides when each of its output clock groups may toggle. It takes an active-low power-down request that may change at any time, brings it into the local clock domain, and only after the request has been seen low on two successive rising edges of the CPU clock group does it stop the groups. Each group is parked low at the end of a complete high phase. Only when every group is parked does the core-enable output drop, which stands in for switching off the PLLs. When the request returns high, the core is re-enabled, a lock interval runs, and each group restarts at the start of a full high phase.

At power-up the block keeps the multiplexed strap pins as inputs and holds everything inactive for as long as the request stays low. Once the request is high for the strap interval, the block captures the strap pins, turns them into outputs, enables the core and then waits the lock interval before it releases the clocks. The group clocks come from internal dividers of the reference clock, one per group, with a half-period set by a parameter. All timers count reference clock cycles.

Top module: `clkpd_ctrl`

## Requirements
- R1: The request passes through a two-flop synchronizer, and groups stop only after the synchronized request has been low at two CPU-group rising edges in a row while running. A low pulse that covers at most one such edge leaves all clocks running.
- R2: Every high pulse on every group clock output lasts exactly that group's half-period (GRP_HALF byte g, in reference cycles). This includes the first pulse after a release and the last pulse before a stop.
- R3: all_stopped_o is 1 when no group is enabled and 0 while any group runs. In a stop, core_en_o falls exactly one cycle after all_stopped_o rises and never falls while any group is enabled.
- R4: While core_en_o is 0, every group clock output is 0.
- R5: After reset, and for as long as the request is low before the first strap capture, strap_oe_o, core_en_o and all group clocks stay 0.
- R6: strap_oe_o and core_en_o rise together STRAP_CYC+3 cycles after the request rises. In that cycle, strap_val_o equals the strap pins sampled at that edge.
- R7: If the request drops before the strap interval ends, the block returns to the held state, and the full interval starts again on the next rise.
- R8: After core_en_o rises, no group clock goes high during the following LOCK_CYC cycles. After that, every group starts toggling.
- R9: Once captured, strap_val_o keeps its value and strap_oe_o stays 1, including through power-down. Later changes on the strap pins are ignored.
- R10: On wake from power-down, core_en_o rises 3 cycles after the request rises, and the clocks resume after the lock interval.
- R11: During reset, all_stopped_o is 1 and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n_i | input | 1 | Asynchronous power-down request, active low |
| strap_pins_i | input | STRAP_W | Levels on the multiplexed strap pins |
| strap_val_o | output | STRAP_W | Captured strap values |
| strap_oe_o | output | 1 | 1 once the strap pins are driven as outputs |
| core_en_o | output | 1 | Core/PLL enable |
| grp_clk_o | output | NUM_GRP | Gated group clocks, group CPU_GRP is the CPU clock |
| all_stopped_o | output | 1 | All groups held low |

## Verification
The pulse-width and power-down properties assume that the request never stays low across two CPU rising edges unless a real stop is intended. The stimulus respects this: its short random low pulses last at most one cycle less than a CPU period, and it holds every real stop request until all_stopped_o is seen. The properties also assume that the strap pins are not watched before capture. The bench changes the strap pins only after the capture or while power is down, and it keeps them fixed through the strap interval.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;

   typedef enum logic [2:0] {
      ST_HOLD  = 3'd0,
      ST_STRAP = 3'd1,
      ST_LOCK  = 3'd2,
      ST_RUN   = 3'd3,
      ST_STOP  = 3'd4,
      ST_DOWN  = 3'd5
   } clkpd_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/clkpd_sync.sv
module clkpd_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkpd_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/clkpd_qual.sv
module clkpd_qual #(
   parameter int unsigned QUAL_SAMPLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic sample_stb_i,
   input  logic req_lvl_i,
   output logic hit_o
);

   localparam int unsigned CNT_W = $clog2(QUAL_SAMPLES + 1);

   logic [CNT_W-1:0] low_cnt_q;

   generate
      if (QUAL_SAMPLES < 1) begin : g_bad_qual
         $error("clkpd_qual: QUAL_SAMPLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt_q <= '0;
      end else if (!arm_i) begin
         low_cnt_q <= '0;
      end else if (sample_stb_i) begin
         if (req_lvl_i) begin
            low_cnt_q <= '0;
         end else if (low_cnt_q != CNT_W'(QUAL_SAMPLES)) begin
            low_cnt_q <= low_cnt_q + 1'b1;
         end
      end
   end

   assign hit_o = arm_i && (low_cnt_q == CNT_W'(QUAL_SAMPLES));

endmodule

// File: rtl/clkpd_grp_gate.sv
module clkpd_grp_gate #(
   parameter int unsigned HALF   = 2,
   parameter int unsigned HALF_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic run_goal_i,
   output logic clk_o,
   output logic run_o,
   output logic rise_o
);

   logic [HALF_W-1:0] cnt_q, cnt_d;
   logic              ph_q, ph_d;
   logic              run_q, run_d;
   logic              wrap;

   generate
      if (HALF < 1 || HALF >= (1 << HALF_W)) begin : g_bad_half
         $error("clkpd_grp_gate: HALF out of range");
      end
   endgenerate

   assign wrap = (cnt_q == HALF_W'(HALF - 1));

   always_comb begin
      if (en_i) begin
         cnt_d = wrap ? '0 : cnt_q + 1'b1;
         ph_d  = wrap ? ~ph_q : ph_q;
      end else begin
         cnt_d = '0;
         ph_d  = 1'b0;
      end
      // gate state may only change while the next phase is low
      run_d = ph_d ? run_q : run_goal_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ph_q  <= 1'b0;
         run_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         ph_q  <= ph_d;
         run_q <= run_d;
      end
   end

   assign clk_o  = ph_q & run_q;
   assign run_o  = run_q;
   assign rise_o = ph_d & ~ph_q;

endmodule

// File: rtl/clkpd_seq.sv
module clkpd_seq
   import clkpd_pkg::*;
#(
   parameter int unsigned STRAP_CYC = 200,
   parameter int unsigned LOCK_CYC  = 100,
   parameter int unsigned STRAP_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_s_i,
   input  logic               qual_hit_i,
   input  logic               all_stopped_i,
   input  logic [STRAP_W-1:0] strap_pins_i,
   output logic [STRAP_W-1:0] strap_val_o,
   output logic               strap_oe_o,
   output logic               core_en_o,
   output logic               run_goal_o,
   output logic               qual_arm_o
);

   localparam int unsigned MAX_CYC = max2(STRAP_CYC, LOCK_CYC);
   localparam int unsigned TMR_W   = $clog2(MAX_CYC + 1);

   clkpd_state_e       state_q;
   logic [TMR_W-1:0]   tmr_q;
   logic [STRAP_W-1:0] strap_q;

   generate
      if (STRAP_CYC < 2 || LOCK_CYC < 2) begin : g_bad_timers
         $error("clkpd_seq: STRAP_CYC and LOCK_CYC must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HOLD;
         tmr_q   <= '0;
         strap_q <= '0;
      end else begin
         case (state_q)
            ST_HOLD: begin
               if (req_s_i) begin
                  state_q <= ST_STRAP;
                  tmr_q   <= '0;
               end
            end
            ST_STRAP: begin
               if (!req_s_i) begin
                  state_q <= ST_HOLD;
                  tmr_q   <= '0;
               end else if (tmr_q == TMR_W'(STRAP_CYC - 1)) begin
                  state_q <= ST_LOCK;
                  tmr_q   <= '0;
                  strap_q <= strap_pins_i;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_LOCK: begin
               if (tmr_q == TMR_W'(LOCK_CYC - 1)) begin
                  state_q <= ST_RUN;
                  tmr_q   <= '0;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            ST_RUN: begin
               if (qual_hit_i) begin
                  state_q <= ST_STOP;
               end
            end
            ST_STOP: begin
               if (all_stopped_i) begin
                  state_q <= ST_DOWN;
               end
            end
            ST_DOWN: begin
               if (req_s_i) begin
                  state_q <= ST_LOCK;
                  tmr_q   <= '0;
               end
            end
            default: begin
               state_q <= ST_HOLD;
               tmr_q   <= '0;
            end
         endcase
      end
   end

   assign strap_val_o = strap_q;
   assign strap_oe_o  = (state_q != ST_HOLD) && (state_q != ST_STRAP);
   assign core_en_o   = (state_q == ST_LOCK) || (state_q == ST_RUN) || (state_q == ST_STOP);
   assign run_goal_o  = (state_q == ST_RUN);
   assign qual_arm_o  = (state_q == ST_RUN);

endmodule

// File: rtl/clkpd_ctrl.sv
module clkpd_ctrl #(
   parameter int unsigned           NUM_GRP      = 4,
   parameter int unsigned           HALF_W       = 8,
   parameter logic [NUM_GRP*8-1:0]  GRP_HALF     = {8'd6, 8'd4, 8'd3, 8'd2},
   parameter int unsigned           CPU_GRP      = 0,
   parameter int unsigned           SYNC_STAGES  = 2,
   parameter int unsigned           QUAL_SAMPLES = 2,
   parameter int unsigned           STRAP_CYC    = 200,
   parameter int unsigned           LOCK_CYC     = 100,
   parameter int unsigned           STRAP_W      = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pd_req_n_i,
   input  logic [STRAP_W-1:0] strap_pins_i,
   output logic [STRAP_W-1:0] strap_val_o,
   output logic               strap_oe_o,
   output logic               core_en_o,
   output logic [NUM_GRP-1:0] grp_clk_o,
   output logic               all_stopped_o
);

   localparam logic [NUM_GRP-1:0] CPU_MASK = NUM_GRP'(1) << CPU_GRP;

   logic               req_s;
   logic               qual_hit;
   logic               qual_arm;
   logic               run_goal;
   logic               cpu_rise;
   logic [NUM_GRP-1:0] run_v;
   logic [NUM_GRP-1:0] rise_v;

   generate
      if (NUM_GRP < 1 || CPU_GRP >= NUM_GRP) begin : g_bad_grp
         $error("clkpd_ctrl: CPU_GRP must index an existing group");
      end
      if (HALF_W > 8) begin : g_bad_hw
         $error("clkpd_ctrl: half-period fields are 8 bits wide");
      end
   endgenerate

   clkpd_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) req_sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pd_req_n_i),
      .sync_o  (req_s)
   );

   assign cpu_rise = |(rise_v & CPU_MASK);

   clkpd_qual #(
      .QUAL_SAMPLES (QUAL_SAMPLES)
   ) qual_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .arm_i        (qual_arm),
      .sample_stb_i (cpu_rise),
      .req_lvl_i    (req_s),
      .hit_o        (qual_hit)
   );

   clkpd_seq #(
      .STRAP_CYC (STRAP_CYC),
      .LOCK_CYC  (LOCK_CYC),
      .STRAP_W   (STRAP_W)
   ) seq_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_s_i       (req_s),
      .qual_hit_i    (qual_hit),
      .all_stopped_i (all_stopped_o),
      .strap_pins_i  (strap_pins_i),
      .strap_val_o   (strap_val_o),
      .strap_oe_o    (strap_oe_o),
      .core_en_o     (core_en_o),
      .run_goal_o    (run_goal),
      .qual_arm_o    (qual_arm)
   );

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
         clkpd_grp_gate #(
            .HALF   (int'(GRP_HALF[g*8 +: 8])),
            .HALF_W (HALF_W)
         ) gate_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (core_en_o),
            .run_goal_i (run_goal),
            .clk_o      (grp_clk_o[g]),
            .run_o      (run_v[g]),
            .rise_o     (rise_v[g])
         );
      end
   endgenerate

   assign all_stopped_o = ~|run_v;

endmodule

// File: rtl/clkpd_ctrl_chk.sv
module clkpd_ctrl_chk #(
   parameter int unsigned          NUM_GRP  = 4,
   parameter logic [NUM_GRP*8-1:0] GRP_HALF = {8'd6, 8'd4, 8'd3, 8'd2},
   parameter int unsigned          STRAP_W  = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [STRAP_W-1:0] strap_pins_i,
   input logic [STRAP_W-1:0] strap_val_o,
   input logic               strap_oe_o,
   input logic               core_en_o,
   input logic [NUM_GRP-1:0] grp_clk_o,
   input logic               all_stopped_o
);

   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_pw
         logic [7:0] hcnt_q;
         logic       prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hcnt_q <= '0;
               prev_q <= 1'b0;
            end else begin
               prev_q <= grp_clk_o[g];
               if (grp_clk_o[g]) begin
                  if (hcnt_q != 8'hFF) hcnt_q <= hcnt_q + 1'b1;
               end else begin
                  hcnt_q <= '0;
               end
            end
         end
         // R2
         high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (prev_q && !grp_clk_o[g]) |-> (hcnt_q == GRP_HALF[g*8 +: 8]));
      end
   endgenerate

   // R4
   down_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !core_en_o |-> (grp_clk_o == '0));

   // R3
   core_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_en_o) |-> $past(all_stopped_o));

   // R5
   hold_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strap_oe_o |-> !core_en_o);

   // R6
   strap_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strap_oe_o) |-> (strap_val_o == $past(strap_pins_i)));

   // R9
   strap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strap_oe_o && $past(strap_oe_o)) |-> $stable(strap_val_o));

   // R9
   strap_oe_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(strap_oe_o) |-> strap_oe_o);

endmodule

bind clkpd_ctrl clkpd_ctrl_chk #(
   .NUM_GRP  (NUM_GRP),
   .GRP_HALF (GRP_HALF),
   .STRAP_W  (STRAP_W)
) chk_i (.*);

// File: tb/clkpd_ctrl_tb_top.sv
module clkpd_ctrl_tb_top;

   localparam int unsigned          NUM_GRP   = 4;
   localparam logic [NUM_GRP*8-1:0] GRP_HALF  = {8'd5, 8'd3, 8'd2, 8'd2};
   localparam int unsigned          STRAP_CYC = 20;
   localparam int unsigned          LOCK_CYC  = 12;
   localparam int unsigned          STRAP_W   = 2;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               pd_req_n = 1'b0;
   logic [STRAP_W-1:0] pins = '0;
   logic [STRAP_W-1:0] strap_val;
   logic               strap_oe;
   logic               core_en;
   logic [NUM_GRP-1:0] gclk;
   logic               all_stopped;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   clkpd_ctrl #(
      .NUM_GRP   (NUM_GRP),
      .GRP_HALF  (GRP_HALF),
      .STRAP_CYC (STRAP_CYC),
      .LOCK_CYC  (LOCK_CYC),
      .STRAP_W   (STRAP_W)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .pd_req_n_i    (pd_req_n),
      .strap_pins_i  (pins),
      .strap_val_o   (strap_val),
      .strap_oe_o    (strap_oe),
      .core_en_o     (core_en),
      .grp_clk_o     (gclk),
      .all_stopped_o (all_stopped)
   );

   function automatic int exp_half(input int g);
      return int'(GRP_HALF[g*8 +: 8]);
   endfunction

   function automatic int max_half();
      int m = 0;
      for (int g = 0; g < NUM_GRP; g++) if (exp_half(g) > m) m = exp_half(g);
      return m;
   endfunction

   function automatic int stop_bound();
      return 3 + 2 * 2 * exp_half(0) + 2 + 2 * max_half() + 2;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // R2: pulse width monitor
   int  hc [NUM_GRP];
   bit  pv [NUM_GRP];
   always @(negedge clk) begin
      for (int g = 0; g < NUM_GRP; g++) begin
         if (!rst_n) begin
            hc[g] = 0;
            pv[g] = 1'b0;
         end else begin
            if (pv[g] && !gclk[g]) check(hc[g] == exp_half(g), "R2 high width", hc[g], exp_half(g));
            hc[g] = gclk[g] ? hc[g] + 1 : 0;
            pv[g] = gclk[g];
         end
      end
   end

   task automatic lock_and_start(input string tag);
      bit quiet = 1'b1;
      bit [NUM_GRP-1:0] seen = '0;
      for (int i = 0; i < LOCK_CYC; i++) begin
         tick(1);
         if (gclk != '0) quiet = 1'b0;
      end
      check(quiet, {tag, " quiet lock"}, int'(quiet), 1);
      for (int i = 0; i < 4 * max_half() + 8; i++) begin
         tick(1);
         seen |= gclk;
      end
      check(seen == '1, {tag, " groups start"}, int'(seen), (1 << NUM_GRP) - 1);
   endtask

   task automatic do_stop();
      int n = 0;
      int rises = 0;
      bit p0 = gclk[0];
      bit bad_early = 1'b0;
      pd_req_n = 1'b0;
      while (!all_stopped && n < 300) begin
         tick(1);
         n++;
         if (!p0 && gclk[0] && n >= 3) rises++;
         p0 = gclk[0];
      end
      pd_req_n = 1'b0;
      check(rises >= 2, "R1 two qualifying cpu rises", rises, 2);
      check(n <= stop_bound(), "R1 stop latency bound", n, stop_bound());
      check(core_en == 1'b1, "R3 core on at all_stopped", int'(core_en), 1);
      tick(1);
      check(core_en == 1'b0, "R3 core off next cycle", int'(core_en), 0);
      for (int i = 0; i < 20; i++) begin
         tick(1);
         if (gclk != '0 || !strap_oe) bad_early = 1'b1;
      end
      check(!bad_early, "R4 R9 outputs low, pins driven while down", int'(bad_early), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      int n;
      bit ok;
      logic [STRAP_W-1:0] cap;
      void'($urandom(32'h5eed_c10c));
      pins = STRAP_W'($urandom);
      tick(3);
      // R11
      check(core_en == 0 && strap_oe == 0 && gclk == '0 && strap_val == '0,
            "R11 reset outputs", int'({core_en, strap_oe, gclk}), 0);
      check(all_stopped == 1'b1, "R11 all_stopped in reset", int'(all_stopped), 1);
      rst_n = 1'b1;
      // R5
      ok = 1'b1;
      for (int i = 0; i < 50; i++) begin
         tick(1);
         if (strap_oe || core_en || gclk != '0) ok = 1'b0;
      end
      check(ok, "R5 held while request low", int'(ok), 1);
      // R7 abort
      pd_req_n = 1'b1;
      tick(10);
      pd_req_n = 1'b0;
      ok = 1'b1;
      for (int i = 0; i < 40; i++) begin
         tick(1);
         if (strap_oe || core_en) ok = 1'b0;
      end
      check(ok, "R7 abort returns to hold", int'(ok), 1);
      // R6 / R7 full interval
      pins = STRAP_W'($urandom);
      cap  = pins;
      pd_req_n = 1'b1;
      n = 0;
      do begin
         tick(1);
         n++;
      end while (!strap_oe && n < 500);
      check(n == STRAP_CYC + 3, "R6 R7 strap latency", n, STRAP_CYC + 3);
      check(strap_val == cap, "R6 captured strap value", int'(strap_val), int'(cap));
      check(core_en == 1'b1, "R6 core enabled with capture", int'(core_en), 1);
      // R8
      lock_and_start("R8");
      // R9
      pins = ~cap;
      tick(5);
      check(strap_val == cap, "R9 pins ignored after capture", int'(strap_val), int'(cap));
      tick(20);
      check(all_stopped == 1'b0, "R3 all_stopped low while running", int'(all_stopped), 0);
      // R1 glitch filter, random short pulses
      for (int k = 0; k < 8; k++) begin
         int len = int'($urandom % (2 * exp_half(0) - 1)) + 1;
         tick(int'($urandom % 7));
         pd_req_n = 1'b0;
         tick(len);
         pd_req_n = 1'b1;
         ok = 1'b1;
         for (int i = 0; i < 30; i++) begin
            tick(1);
            if (all_stopped || !core_en) ok = 1'b0;
         end
         check(ok, "R1 short low pulse ignored", int'(ok), 1);
      end
      // stop / wake cycles with random phase
      for (int k = 0; k < 5; k++) begin
         tick(int'($urandom % 11));
         do_stop();
         pins = STRAP_W'($urandom);
         tick(int'($urandom % 9));
         pd_req_n = 1'b1;
         tick(2);
         check(core_en == 1'b0, "R10 core still off after 2", int'(core_en), 0);
         tick(1);
         check(core_en == 1'b1, "R10 core on after 3", int'(core_en), 1);
         lock_and_start("R10");
         check(strap_val == cap, "R9 strap kept over power-down", int'(strap_val), int'(cap));
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule